// File: doc/BRIEF.md
# Interval Timer with Compare Channels

This block is a free-running 16-bit up-counter used as an interval timer. A period compare value D sets the interval. While the timer runs, every count-clock enable pulse moves the count up by one. When the count equals D, the next counted pulse returns it to zero, so one interval lasts D+1 counted pulses. Channel 0 is tied to this period match. It raises a one-cycle interrupt pulse and inverts its toggle output, which gives a square wave with a 50% duty cycle and a half period of one interval.

Channels 1 to 3 compare their own values against the same count. Each one raises its own interrupt pulse and inverts its own toggle output whenever the count equals its value. Software controls the block through a plain write port. It can rewrite any compare value while the timer runs, and the new value takes part in the very next comparison.

Top module: `interval_cmp_timer`

## Requirements
- R1: After reset all interrupt and toggle outputs are 0 and the counter is stopped at 0.
- R2: A write with `wr_addr` 0 loads the control word (bit 0 = run enable, bits 3:1 = mode). A write with `wr_addr` 1+k loads the compare value of channel k (k = 0..3), where channel 0 holds the period value D. The value is used from the first counted pulse after the write cycle.
- R3: The timer counts only while run enable is 1 and mode is 000. Any other control value holds the count at 0 and raises no interrupt.
- R4: The count changes only on cycles where `cnt_tick` is high.
- R5: When a counted pulse finds the count equal to D, channel 0 fires and the count becomes 0. Channel 0 therefore fires once every D+1 counted pulses (every pulse when D = 0). An interrupt appears in the cycle after the counted pulse that caused it.
- R6: Each channel-0 firing inverts `tout_o[0]`, giving a 50%-duty square wave.
- R7: Channels 1 to 3 fire when a counted pulse finds the count equal to their compare value, and each firing inverts that channel's toggle output.
- R8: A channel whose compare value is greater than D never fires, and its toggle output stays 0.
- R9: A compare value rewritten while the timer runs is used from the next counted pulse onward.
- R10: Each firing gives an interrupt that is high for one clock cycle only.
- R11: Clearing run enable resets the count to 0 and returns all toggle outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 control, 1..4 compare channel 0..3 |
| wr_data | input | 16 | Write data |
| cnt_tick | input | 1 | Count-clock enable |
| irq_o | output | 4 | Per-channel match interrupt pulses |
| tout_o | output | 4 | Per-channel toggle outputs |

## Verification
The period is tried with a pulse on every cycle and with a pulse on one cycle in three. The first case fixes the D+1 interval exactly. The second shows that the count ignores cycles without a pulse. D = 0 shows that the period channel fires on every pulse. A secondary value above D shows that a channel can stay idle. Compare values rewritten mid-run separate "effective next pulse" from "effective next period". Disable and re-enable, together with a non-interval mode value, show that a stopped timer clears its outputs and restarts its count from zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_INTERVAL = 3'b000;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              en;
    } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CNT_W-1:0]        wr_data,
    output logic                    run_o,
    output logic [NUM_CH*CNT_W-1:0] cmp_o
);
    localparam int CMP_BITS = NUM_CH * CNT_W;

    typedef struct packed {
        ctrl_t               ctrl;
        logic [CMP_BITS-1:0] cmp;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == '0) begin
                regs_d.ctrl.en   = wr_data[0];
                regs_d.ctrl.mode = wr_data[MODE_W:1];
            end
            for (int k = 0; k < NUM_CH; k++) begin
                if (wr_addr == ADDR_W'(k + 1)) begin
                    regs_d.cmp[k*CNT_W +: CNT_W] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign run_o = regs_q.ctrl.en && (regs_q.ctrl.mode == MODE_INTERVAL);
    assign cmp_o = regs_q.cmp;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             adv_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == per_i) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign adv_o = run_i && tick_i;

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(st_q.cnt));

    // R5
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && (st_q.cnt == per_i)) |=> (st_q.cnt == '0));

    // R11
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             irq_o,
    output logic             tout_o
);
    typedef struct packed {
        logic irq;
        logic tout;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        hit     = adv_i && (cnt_i == cmp_i);
        st_d    = st_q;
        st_d.irq = hit;
        if (!run_i) begin
            st_d.tout = 1'b0;
        end else if (hit) begin
            st_d.tout = !st_q.tout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o  = st_q.irq;
    assign tout_o = st_q.tout;

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!irq_o && !tout_o));

    // R7
    irq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (tout_o != $past(tout_o)));
endmodule

// File: rtl/interval_cmp_timer.sv
module interval_cmp_timer #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              cnt_tick,
    output logic [NUM_CH-1:0] irq_o,
    output logic [NUM_CH-1:0] tout_o
);
    localparam int CMP_BITS = NUM_CH * CNT_W;

    logic                run;
    logic [CMP_BITS-1:0] cmp;
    logic [CNT_W-1:0]    cnt;
    logic                adv;

    tmr_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run_o   (run),
        .cmp_o   (cmp)
    );

    tmr_counter #(.CNT_W(CNT_W)) counter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (cnt_tick),
        .per_i  (cmp[CNT_W-1:0]),
        .cnt_o  (cnt),
        .adv_o  (adv)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        tmr_chan #(.CNT_W(CNT_W)) chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run),
            .adv_i  (adv),
            .cnt_i  (cnt),
            .cmp_i  (cmp[k*CNT_W +: CNT_W]),
            .irq_o  (irq_o[k]),
            .tout_o (tout_o[k])
        );
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));
endmodule

// File: tb/interval_cmp_timer_tb.sv
module interval_cmp_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic       cnt_tick = 1'b0;
    logic [3:0] irq_o;
    logic [3:0] tout_o;

    interval_cmp_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cnt_tick (cnt_tick),
        .irq_o    (irq_o),
        .tout_o   (tout_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int cyc;
        int ch;
        bit lvl;
    } evt_t;

    evt_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;

    bit       run_m = 1'b0;
    int       c_m[4] = '{0, 0, 0, 0};
    int       m = 0;
    bit [3:0] lvl = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: set inputs for the next edge, push the expected events of that edge
    task automatic step(input bit tick, input bit we, input int addr, input int data);
        int e;
        e = cyc + 1;
        cnt_tick = tick;
        wr_en    = we;
        wr_addr  = 3'(addr);
        wr_data  = 16'(data);
        if (run_m) begin
            if (tick) begin
                for (int ch = 0; ch < 4; ch++) begin
                    if (m == c_m[ch]) begin
                        lvl[ch] = ~lvl[ch];
                        q.push_back('{e, ch, lvl[ch]});
                    end
                end
                m = (m == c_m[0]) ? 0 : ((m + 1) & 16'hFFFF);
            end
        end else begin
            m   = 0;
            lvl = '0;
        end
        if (we) begin
            if (addr == 0) run_m = data[0] && (((data >> 1) & 7) == 0);
            else           c_m[addr-1] = data & 16'hFFFF;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n, input int every);
        for (int i = 0; i < n; i++) step(((cyc + 1) % every) == 0, 1'b0, 0, 0);
    endtask

    task automatic drain(input string req);
        run_ticks(3, 1000000);
        check(q.size() == 0, req, q.size(), 0);
    endtask

    // monitor: pops expected events as interrupts appear
    always @(negedge clk) begin
        if (mon_on) begin
            while (q.size() > 0 && q[0].cyc < cyc) begin
                check(1'b0, "R5/R7 missed interrupt", q[0].ch, q[0].cyc);
                void'(q.pop_front());
            end
            for (int ch = 0; ch < 4; ch++) begin
                if (irq_o[ch]) begin
                    if (q.size() > 0 && q[0].cyc == cyc && q[0].ch == ch) begin
                        check(tout_o[ch] == q[0].lvl, "R6/R7 toggle level", tout_o[ch], q[0].lvl);
                        void'(q.pop_front());
                    end else begin
                        check(1'b0, "R10/R8 unexpected interrupt", ch, -1);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(irq_o == 4'b0, "R1 irq after reset", irq_o, 0);
        check(tout_o == 4'b0, "R1 tout after reset", tout_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R2 R5 R6 R7 R8: D=5, ch1=2, ch2=5, ch3=9 (> D), tick every cycle
        step(1'b0, 1'b1, 1, 5);
        step(1'b0, 1'b1, 2, 2);
        step(1'b0, 1'b1, 3, 5);
        step(1'b0, 1'b1, 4, 9);
        step(1'b0, 1'b1, 0, 1);
        run_ticks(40, 1);
        check(tout_o[3] == 1'b0, "R8 idle channel toggle", tout_o[3], 0);
        check(q.size() == 0, "R5 pending events", q.size(), 0);

        // R11: disable clears outputs
        step(1'b0, 1'b1, 0, 0);
        step(1'b1, 1'b0, 0, 0);
        step(1'b1, 1'b0, 0, 0);
        check(tout_o == 4'b0, "R11 tout after disable", tout_o, 0);
        drain("R11 no events while stopped");

        // R4: D=3, tick one cycle in three
        step(1'b0, 1'b1, 1, 3);
        step(1'b0, 1'b1, 2, 1);
        step(1'b0, 1'b1, 3, 3);
        step(1'b0, 1'b1, 4, 0);
        step(1'b0, 1'b1, 0, 1);
        run_ticks(60, 3);
        drain("R4 sparse ticks");

        // R9: rewrite compare values mid-run (period and channel 1)
        step(1'b1, 1'b1, 2, 0);
        run_ticks(10, 1);
        step(1'b1, 1'b1, 1, 6);
        run_ticks(20, 1);
        step(1'b1, 1'b1, 4, 6);
        run_ticks(20, 1);
        drain("R9 rewrite while running");

        // R5 boundary: D=0 fires on every pulse
        step(1'b0, 1'b1, 0, 0);
        step(1'b0, 1'b1, 1, 0);
        step(1'b0, 1'b1, 0, 1);
        run_ticks(8, 1);
        drain("R5 zero period");
        check(q.size() == 0, "R10 pulse events", q.size(), 0);

        // R3: enabled with a non-interval mode value stays idle
        step(1'b0, 1'b1, 0, 0);
        step(1'b0, 1'b1, 1, 2);
        step(1'b0, 1'b1, 0, 16'h0005);
        run_ticks(20, 1);
        check(tout_o == 4'b0, "R3 tout in other mode", tout_o, 0);
        check(irq_o == 4'b0, "R3 irq in other mode", irq_o, 0);

        // R11/R2: re-enable restarts from zero
        step(1'b0, 1'b1, 0, 1);
        run_ticks(15, 1);
        drain("R11 restart from zero");

        mon_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule